// File: doc/BRIEF.md
# Card Slot Power and Reset Sequencer

This block walks an add-in card slot through bring-up and tear-down. On a start request, and only while a card sits in the slot, it holds the card's active-low fundamental reset and turns on the rails in a fixed order. Each step waits for its own good indication: the auxiliary supply, then the main supply, then the reference clock. It then enables the link controller's training state machine. It lets the card out of reset only once the minimum dwell times since main power and since a stable reference clock have both passed. When the link reports up, it waits a settle interval and then raises a flag saying configuration accesses may begin.

Tear-down starts from the ready state on a stop request. The block first asks the link side to move the card into its low-power D3hot state and waits for an acknowledge, or for a timeout. It then asserts reset, removes main power on the next cycle, and removes the clock, the auxiliary rail and training enable on the cycle after that. If main power-good drops while the card is powered, reset goes low with no clock edge in between, and the block moves to a fault state with all rails off. A missing power-good or link-up indication also ends in that fault state. All delays are given in microseconds and turned into cycle counts from a clock-rate parameter, so a bench can shrink them.

Top module: `slot_pwr_seq`

## Requirements
- R1: While reset is applied, and right after it, reset-out is low (perst_n_o=0), and aux_en_o, main_en_o, refclk_en_o, ltssm_en_o, d3_req_o, cfg_ready_o and err_o are all 0.
- R2: A start request is ignored when card_present_i is 0: aux_en_o stays 0, and from the fault state err_o stays 1.
- R3: Power-up enables aux_en_o one cycle after start. main_en_o follows one cycle after aux_pg_i is seen, refclk_en_o one cycle after main_pg_i is seen, and ltssm_en_o one cycle after refclk_ok_i is seen. perst_n_o goes high only while all four enables are high.
- R4: perst_n_o rises no earlier than MAIN_US worth of cycles after main_pg_i is first sampled high, and no earlier than REFCLK_US worth of cycles after refclk_ok_i is first sampled high. It rises within two cycles of the later of these two limits.
- R5: The link-up source is dll_active_i when std_cap_i=1 and vendor_link_i when std_cap_i=0. The unselected input has no effect.
- R6: cfg_ready_o rises exactly SETTLE_US worth of cycles after the clock edge that first samples the selected link-up high.
- R7: A stop_i seen in the ready state raises d3_req_o on the next cycle. After d3_ack_i is sampled, perst_n_o falls and d3_req_o and cfg_ready_o clear. main_en_o falls one cycle later. refclk_en_o, aux_en_o and ltssm_en_o fall one cycle after that.
- R8: If d3_ack_i does not arrive, perst_n_o falls exactly TIMEOUT_US worth of cycles after d3_req_o rises, and the rest of the power-down order follows.
- R9: When main_pg_i falls after main power was reported good, perst_n_o falls in the same instant with no clock edge. On the next edge, err_o rises and every enable clears.
- R10: If aux_pg_i, main_pg_i, refclk_ok_i or the link-up is missing for TIMEOUT_US worth of cycles after the step that waits for it began, err_o rises. In the fault state perst_n_o is low and all enables are 0.
- R11: The fault state holds until a start request arrives with a card present. That request clears err_o and starts a new power-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Power-up request |
| stop_i | input | 1 | Orderly power-down request |
| card_present_i | input | 1 | Card detected in slot |
| aux_pg_i | input | 1 | Auxiliary rail power-good |
| main_pg_i | input | 1 | Main rail power-good |
| refclk_ok_i | input | 1 | Reference clock stable |
| std_cap_i | input | 1 | 1 selects the standard link-active bit as link-up source |
| dll_active_i | input | 1 | Standard data-link-layer-active status |
| vendor_link_i | input | 1 | Vendor-specific link-up status |
| d3_ack_i | input | 1 | Link side reports the card is in D3hot and the link inactive |
| perst_n_o | output | 1 | Active-low card reset |
| aux_en_o | output | 1 | Auxiliary rail enable |
| main_en_o | output | 1 | Main rail enable |
| refclk_en_o | output | 1 | Reference clock enable |
| ltssm_en_o | output | 1 | Link training enable to the controller |
| d3_req_o | output | 1 | Request to move the card into D3hot |
| cfg_ready_o | output | 1 | Configuration access allowed |
| err_o | output | 1 | Fault flag |

## Verification
The hardest case to set up is the one where the reference clock, not main power, sets the release time. The clock must turn stable late enough that its short dwell ends after the long main-power dwell, yet soon enough that the wait for the clock does not time out. The stimulus covers this with a directed run that holds refclk_ok_i back for most of the main dwell. It also draws random clock gaps, so the release edge is measured against both limits. The loss of main power-good while ready is also reached on purpose, to catch the reset output dropping with no clock edge.

// File: rtl/slot_seq_pkg.sv
package slot_seq_pkg;

    typedef enum logic [3:0] {
        S_OFF,
        S_AUX,
        S_MAIN,
        S_CLK,
        S_HOLD,
        S_LINK,
        S_SETTLE,
        S_READY,
        S_D3,
        S_DN_RST,
        S_DN_MAIN,
        S_FAULT
    } seq_state_e;

    // microseconds to clock cycles, never below one cycle
    function automatic int unsigned us_to_cycles(input int unsigned khz, input int unsigned us);
        logic [63:0] prod;
        prod = 64'(khz) * 64'(us);
        prod = prod / 64'd1000;
        if (prod == 64'd0) prod = 64'd1;
        return prod[31:0];
    endfunction

endpackage

// File: rtl/slot_stable_timer.sv
module slot_stable_timer #(
    parameter int unsigned LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic done_o
);
    localparam int unsigned W = $clog2(LIMIT + 1);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (!run_i)
            cnt_d = '0;
        else if (cnt_q != W'(LIMIT))
            cnt_d = cnt_q + 1'b1;
        else
            cnt_d = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign done_o = (cnt_q == W'(LIMIT));

    // the dwell restarts from zero whenever its condition drops (R4)
    assert_dwell_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> !done_o);

endmodule

// File: rtl/slot_link_select.sv
module slot_link_select (
    input  logic std_cap_i,
    input  logic std_link_i,
    input  logic vnd_link_i,
    output logic link_o
);
    always_comb begin
        link_o = std_cap_i ? std_link_i : vnd_link_i;
    end
endmodule

// File: rtl/slot_pwr_seq.sv
module slot_pwr_seq
    import slot_seq_pkg::*;
#(
    parameter int unsigned CLK_KHZ    = 50000,
    parameter int unsigned MAIN_US    = 100000,
    parameter int unsigned REFCLK_US  = 100,
    parameter int unsigned SETTLE_US  = 100000,
    parameter int unsigned TIMEOUT_US = 200000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic stop_i,
    input  logic card_present_i,
    input  logic aux_pg_i,
    input  logic main_pg_i,
    input  logic refclk_ok_i,
    input  logic std_cap_i,
    input  logic dll_active_i,
    input  logic vendor_link_i,
    input  logic d3_ack_i,
    output logic perst_n_o,
    output logic aux_en_o,
    output logic main_en_o,
    output logic refclk_en_o,
    output logic ltssm_en_o,
    output logic d3_req_o,
    output logic cfg_ready_o,
    output logic err_o
);
    localparam int unsigned MAIN_CYC   = us_to_cycles(CLK_KHZ, MAIN_US);
    localparam int unsigned REFCLK_CYC = us_to_cycles(CLK_KHZ, REFCLK_US);
    localparam int unsigned SETTLE_CYC = us_to_cycles(CLK_KHZ, SETTLE_US);
    localparam int unsigned TO_CYC     = us_to_cycles(CLK_KHZ, TIMEOUT_US);
    localparam int unsigned CNT_MAX    = (TO_CYC > SETTLE_CYC) ? TO_CYC : SETTLE_CYC;
    localparam int unsigned CW         = $clog2(CNT_MAX + 1);

    typedef struct packed {
        seq_state_e    st;
        logic          perst_n;
        logic          aux_en;
        logic          main_en;
        logic          clk_en;
        logic          ltssm_en;
        logic          d3_req;
        logic          ready;
        logic          err;
        logic [CW-1:0] cnt;
    } seq_regs_t;

    seq_regs_t d, q;

    logic link_up;
    logic main_done;
    logic clk_done;
    logic go_fault;
    logic tmo_hit;
    logic settle_hit;
    logic main_lost;

    slot_link_select u_link_sel (
        .std_cap_i  (std_cap_i),
        .std_link_i (dll_active_i),
        .vnd_link_i (vendor_link_i),
        .link_o     (link_up)
    );

    slot_stable_timer #(.LIMIT(MAIN_CYC)) u_main_dwell (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (q.main_en & main_pg_i),
        .done_o (main_done)
    );

    slot_stable_timer #(.LIMIT(REFCLK_CYC)) u_clk_dwell (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (q.clk_en & refclk_ok_i),
        .done_o (clk_done)
    );

    assign tmo_hit    = (q.cnt == CW'(TO_CYC - 1));
    assign settle_hit = (q.cnt == CW'(SETTLE_CYC - 1));
    assign main_lost  = !main_pg_i;

    always_comb begin
        d        = q;
        go_fault = 1'b0;
        case (q.st)
            S_OFF, S_FAULT: begin
                if (start_i && card_present_i) begin
                    d        = '0;
                    d.st     = S_AUX;
                    d.aux_en = 1'b1;
                end
            end
            S_AUX: begin
                if (aux_pg_i) begin
                    d.st      = S_MAIN;
                    d.main_en = 1'b1;
                    d.cnt     = '0;
                end else if (tmo_hit) begin
                    go_fault = 1'b1;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            S_MAIN: begin
                if (main_pg_i) begin
                    d.st     = S_CLK;
                    d.clk_en = 1'b1;
                    d.cnt    = '0;
                end else if (tmo_hit) begin
                    go_fault = 1'b1;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            S_CLK: begin
                if (main_lost) begin
                    go_fault = 1'b1;
                end else if (refclk_ok_i) begin
                    d.st       = S_HOLD;
                    d.ltssm_en = 1'b1;
                    d.cnt      = '0;
                end else if (tmo_hit) begin
                    go_fault = 1'b1;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            S_HOLD: begin
                if (main_lost) begin
                    go_fault = 1'b1;
                end else if (main_done && clk_done) begin
                    d.st      = S_LINK;
                    d.perst_n = 1'b1;
                    d.cnt     = '0;
                end
            end
            S_LINK: begin
                if (main_lost) begin
                    go_fault = 1'b1;
                end else if (link_up) begin
                    d.st  = S_SETTLE;
                    d.cnt = '0;
                end else if (tmo_hit) begin
                    go_fault = 1'b1;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            S_SETTLE: begin
                if (main_lost) begin
                    go_fault = 1'b1;
                end else if (settle_hit) begin
                    d.st    = S_READY;
                    d.ready = 1'b1;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            S_READY: begin
                if (main_lost) begin
                    go_fault = 1'b1;
                end else if (stop_i) begin
                    d.st     = S_D3;
                    d.d3_req = 1'b1;
                    d.cnt    = '0;
                end
            end
            S_D3: begin
                if (main_lost) begin
                    go_fault = 1'b1;
                end else if (d3_ack_i || tmo_hit) begin
                    d.st      = S_DN_RST;
                    d.perst_n = 1'b0;
                    d.ready   = 1'b0;
                    d.d3_req  = 1'b0;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            S_DN_RST: begin
                d.st      = S_DN_MAIN;
                d.main_en = 1'b0;
            end
            S_DN_MAIN: begin
                d.st       = S_OFF;
                d.clk_en   = 1'b0;
                d.aux_en   = 1'b0;
                d.ltssm_en = 1'b0;
            end
            default: go_fault = 1'b1;
        endcase

        if (go_fault) begin
            d     = '0;
            d.st  = S_FAULT;
            d.err = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // fast path: loss of main power-good pulls reset without waiting for a clock
    assign perst_n_o   = q.perst_n & main_pg_i;
    assign aux_en_o    = q.aux_en;
    assign main_en_o   = q.main_en;
    assign refclk_en_o = q.clk_en;
    assign ltssm_en_o  = q.ltssm_en;
    assign d3_req_o    = q.d3_req;
    assign cfg_ready_o = q.ready;
    assign err_o       = q.err;

    assert_release_rails_R3: assert property (@(posedge clk) disable iff (!rst_n)
        perst_n_o |-> (aux_en_o && main_en_o && refclk_en_o && ltssm_en_o));

    assert_main_needs_aux_R3: assert property (@(posedge clk) disable iff (!rst_n)
        main_en_o |-> aux_en_o);

    assert_release_dwell_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.perst_n) |-> (main_done && clk_done));

    assert_no_card_no_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_OFF && start_i && !card_present_i) |=> !aux_en_o);

    assert_main_off_after_reset_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(main_en_o) |-> !perst_n_o);

    assert_loss_to_fault_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_READY && !main_pg_i) |=> err_o);

    assert_fault_safe_R10: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (!perst_n_o && !main_en_o && !aux_en_o && !cfg_ready_o));

endmodule

// File: tb/slot_pwr_seq_tb.sv
module slot_pwr_seq_tb_top;

    localparam int MAIN_C = 40;
    localparam int CLK_C  = 10;
    localparam int SET_C  = 30;
    localparam int TO_C   = 60;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 0, stop = 0, present = 0;
    logic aux_pg = 0, main_pg = 0, rck_ok = 0;
    logic cap = 0, dlla = 0, vlink = 0, d3_ack = 0;
    logic perst_n_o, aux_en_o, main_en_o, refclk_en_o, ltssm_en_o, d3_req_o, cfg_ready_o, err_o;

    int checks = 0;
    int fails = 0;

    always #10 clk = ~clk;

    slot_pwr_seq #(
        .CLK_KHZ(1000), .MAIN_US(MAIN_C), .REFCLK_US(CLK_C),
        .SETTLE_US(SET_C), .TIMEOUT_US(TO_C)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start), .stop_i(stop),
        .card_present_i(present), .aux_pg_i(aux_pg), .main_pg_i(main_pg),
        .refclk_ok_i(rck_ok), .std_cap_i(cap), .dll_active_i(dlla),
        .vendor_link_i(vlink), .d3_ack_i(d3_ack), .perst_n_o(perst_n_o),
        .aux_en_o(aux_en_o), .main_en_o(main_en_o), .refclk_en_o(refclk_en_o),
        .ltssm_en_o(ltssm_en_o), .d3_req_o(d3_req_o), .cfg_ready_o(cfg_ready_o),
        .err_o(err_o)
    );

    function automatic bit exp_link(input bit c, input bit d, input bit v);
        return c ? d : v;
    endfunction

    function automatic int slack(input int n_main, input int n_clk);
        int a, b;
        a = n_main - MAIN_C;
        b = n_clk - CLK_C;
        return (a < b) ? a : b;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic clear_inputs();
        aux_pg = 0; main_pg = 0; rck_ok = 0; dlla = 0; vlink = 0; d3_ack = 0;
        start = 0; stop = 0;
    endtask

    task automatic pulse_start();
        start = 1;
        step();
        start = 0;
    endtask

    task automatic power_up(input bit cap_sel, input int aux_gap, input int main_gap,
                            input int rck_gap, input bit give_link);
        int nm, nc;
        clear_inputs();
        cap = cap_sel;
        pulse_start();
        chk("R3 aux on after start", aux_en_o, 1);
        chk("R11 err cleared by start", err_o, 0);
        repeat (aux_gap) step();
        chk("R3 main waits for aux pg", main_en_o, 0);
        aux_pg = 1;
        step();
        chk("R3 main on", main_en_o, 1);
        chk("R3 refclk still off", refclk_en_o, 0);
        repeat (main_gap) step();
        main_pg = 1;
        nm = 0;
        step(); nm++;
        chk("R3 refclk on", refclk_en_o, 1);
        chk("R3 ltssm still off", ltssm_en_o, 0);
        for (int i = 0; i < rck_gap; i++) begin step(); nm++; end
        chk("R3 ltssm waits for refclk", ltssm_en_o, 0);
        rck_ok = 1;
        nc = 0;
        step(); nm++; nc++;
        chk("R3 ltssm before release", ltssm_en_o, 1);
        chk("R3 reset held", perst_n_o, 0);
        while (!perst_n_o && nm < 500) begin step(); nm++; nc++; end
        chk("R4 main dwell met", int'(nm >= MAIN_C), 1);
        chk("R4 refclk dwell met", int'(nc >= CLK_C), 1);
        chk("R4 release not late", int'(slack(nm, nc) <= 2), 1);
        if (give_link) begin
            if (cap_sel) begin dlla = 0; vlink = 1; end
            else         begin dlla = 1; vlink = 0; end
            repeat (5) step();
            chk("R5 unselected source ignored", cfg_ready_o, int'(exp_link(cap_sel, dlla, vlink)));
            chk("R5 no timeout yet", err_o, 0);
            if (cap_sel) dlla = 1; else vlink = 1;
            repeat (SET_C) step();
            chk("R6 ready not early", cfg_ready_o, 0);
            step();
            chk("R6 ready on time", cfg_ready_o, int'(exp_link(cap_sel, dlla, vlink)));
        end else begin
            repeat (TO_C - 1) step();
            chk("R10 link wait before timeout", err_o, 0);
            step();
            chk("R10 link timeout", err_o, 1);
            chk("R10 fault holds reset", perst_n_o, 0);
            clear_inputs();
        end
    endtask

    task automatic power_down(input int ack_gap);
        stop = 1;
        step();
        stop = 0;
        chk("R7 d3 request", d3_req_o, 1);
        chk("R7 reset still released", perst_n_o, 1);
        if (ack_gap < TO_C) begin
            repeat (ack_gap) step();
            chk("R7 waits for ack", perst_n_o, 1);
            d3_ack = 1;
            step();
            chk("R7 reset asserted", perst_n_o, 0);
            chk("R7 main still on", main_en_o, 1);
            chk("R7 d3 request cleared", d3_req_o, 0);
        end else begin
            repeat (TO_C - 1) step();
            chk("R8 before ack timeout", perst_n_o, 1);
            step();
            chk("R8 ack timeout asserts reset", perst_n_o, 0);
            chk("R8 main still on", main_en_o, 1);
        end
        step();
        chk("R7 main off", main_en_o, 0);
        chk("R7 refclk still on", refclk_en_o, 1);
        step();
        chk("R7 refclk off", refclk_en_o, 0);
        chk("R7 aux off", aux_en_o, 0);
        chk("R7 ltssm off", ltssm_en_o, 0);
        clear_inputs();
        step();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h1A2B3C4D));
        repeat (3) step();
        chk("R1 reset perst", perst_n_o, 0);
        chk("R1 reset rails", int'({aux_en_o, main_en_o, refclk_en_o, ltssm_en_o}), 0);
        chk("R1 reset flags", int'({d3_req_o, cfg_ready_o, err_o}), 0);
        rst_n = 1;
        step();
        chk("R1 after reset", int'({perst_n_o, aux_en_o, err_o}), 0);

        present = 0;
        pulse_start();
        repeat (3) step();
        chk("R2 no card no power", aux_en_o, 0);
        present = 1;

        power_up(1'b1, 0, 0, 0, 1'b1);
        power_down(0);

        // reference clock late enough to set the release time
        power_up(1'b0, 2, 3, 35, 1'b1);
        power_down(TO_C);

        for (int k = 0; k < 6; k++) begin
            power_up(1'($urandom % 2), int'($urandom % 12), int'($urandom % 12),
                     int'($urandom % 40), 1'b1);
            power_down(int'($urandom % 6));
        end

        // surprise loss of main power while ready
        power_up(1'b1, 1, 1, 1, 1'b1);
        main_pg = 0;
        #1;
        chk("R9 reset drops without clock", perst_n_o, 0);
        step();
        chk("R9 fault flag", err_o, 1);
        chk("R9 rails off", int'({aux_en_o, main_en_o, refclk_en_o}), 0);
        clear_inputs();

        // aux power-good never arrives
        pulse_start();
        repeat (TO_C - 1) step();
        chk("R10 aux wait before timeout", err_o, 0);
        step();
        chk("R10 aux timeout", err_o, 1);
        chk("R10 fault rails off", aux_en_o, 0);

        present = 0;
        pulse_start();
        step();
        chk("R2 no card in fault", aux_en_o, 0);
        chk("R11 fault held", err_o, 1);
        present = 1;

        power_up(1'b1, 1, 1, 1, 1'b0);
        power_up(1'b0, 4, 0, 5, 1'b1);
        power_down(3);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule